// File: doc/BRIEF.md
# USB Bulk Transmit Packet Segmenter

This block moves one bulk transfer of a programmed byte count from a byte source into an endpoint transmit FIFO, cutting it into packets no larger than the endpoint's maximum packet size. Before each packet it waits until the FIFO reports room for a whole packet. It then streams the packet's bytes through and closes the packet with a one-cycle packet-ready strobe. When the transfer is over it raises a single one-cycle done interrupt.

Two modes are offered. Multi-packet mode carries the whole transfer under one start command and interrupts once at the end. If the byte count is an exact multiple of the packet size, or is zero, the block appends a zero-length packet so that the receiver can see where the transfer ends. Single-packet mode loads one packet per start command and interrupts after that packet.

The byte source is a valid/ready stream. A byte moves only in a cycle where `src_valid_i` and `src_ready_o` are both high. The source may raise or drop valid at any time, and while ready is low nothing is taken. `src_ready_o` does not depend on `src_valid_i`. The FIFO side has no back-pressure within a packet, because space for the whole packet is confirmed before the packet starts.

Top module: `usb_bulk_tx_segmenter`

## Requirements
- R1: In multi-packet mode, a transfer of L bytes with packet size M is delivered as consecutive packets of M bytes each. `pkt_ready_o` pulses in the cycle after the write of each packet's last byte.
- R2: When L is not a multiple of M, the final packet carries L mod M bytes and no zero-length packet follows it.
- R3: In multi-packet mode, when L is a non-zero multiple of M, exactly one zero-length packet follows the last full packet. A zero-length packet is a `pkt_ready_o` pulse with no FIFO write since the previous pulse.
- R4: In multi-packet mode with L = 0, the block sends exactly one zero-length packet and then signals done.
- R5: In single-packet mode, the block writes min(L, M) bytes, pulses `pkt_ready_o` once and then signals done. With L = 0 the single packet is zero-length.
- R6: `done_irq_o` is a one-cycle pulse, given exactly once per transfer, in the cycle right after the transfer's final `pkt_ready_o`.
- R7: A packet, including a zero-length one, starts only after `fifo_space_i` is sampled high while the block is waiting between packets. `src_ready_o` stays low while it waits.
- R8: `src_ready_o` is high only while a packet is being filled. `fifo_wr_o` equals `src_valid_i` and `src_ready_o` together, and `fifo_data_o` equals `src_data_i` in every write cycle.
- R9: A start command that arrives while a transfer is in progress is ignored and does not change the transfer in progress.
- R10: After reset `src_ready_o`, `fifo_wr_o`, `pkt_ready_o` and `done_irq_o` are low, and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a transfer when idle |
| multi_i | input | 1 | 1 = multi-packet mode, 0 = single-packet mode; sampled at start |
| total_len_i | input | LEN_W | Transfer length in bytes; sampled at start |
| max_pkt_i | input | PKT_W | Maximum packet size in bytes, non-zero; sampled at start |
| fifo_space_i | input | 1 | FIFO has room for a full packet |
| src_valid_i | input | 1 | Source byte valid |
| src_data_i | input | DATA_W | Source byte |
| src_ready_o | output | 1 | Block accepts a source byte |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | DATA_W | FIFO write data |
| pkt_ready_o | output | 1 | Current packet is complete and ready to send |
| done_irq_o | output | 1 | Transfer complete interrupt pulse |

## Verification
The hardest situation to reach is the wait before the trailing zero-length packet. It needs a multi-packet transfer whose length is an exact multiple of the packet size, and the FIFO must also withhold space at that moment. The stimulus runs exact-multiple lengths, including a zero length and a packet size of one, while `fifo_space_i` and `src_valid_i` are randomised every cycle. This parks the block in that wait several times per run. Stray start pulses with unrelated lengths are injected mid-transfer, and a cycle-accurate reference model in the bench catches any of them being taken.

// File: rtl/usb_seg_pkg.sv
package usb_seg_pkg;
  typedef enum logic [2:0] {
    SEG_IDLE   = 3'd0,
    SEG_WAIT   = 3'd1,
    SEG_FILL   = 3'd2,
    SEG_COMMIT = 3'd3,
    SEG_NULL   = 3'd4,
    SEG_DONE   = 3'd5
  } seg_state_e;
endpackage

// File: rtl/seg_len_tracker.sv
module seg_len_tracker #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             beat_i,
  output logic [LEN_W-1:0] rem_o,
  output logic             rem_zero_o
);
  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (load_i) rem_q <= len_i;
    else if (beat_i) rem_q <= rem_q - LEN_W'(1);
  end

  assign rem_o      = rem_q;
  assign rem_zero_o = (rem_q == '0);

  // the whole transfer can never be overdrawn
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    beat_i |-> rem_q != '0); // R1
endmodule

// File: rtl/seg_pkt_tracker.sv
module seg_pkt_tracker #(
  parameter int LEN_W = 16,
  parameter int PKT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] rem_i,
  input  logic [PKT_W-1:0] max_i,
  input  logic             beat_i,
  output logic             last_beat_o,
  output logic             full_o
);
  localparam int WIDE_W = (LEN_W > PKT_W) ? LEN_W : PKT_W;

  logic [PKT_W-1:0]  left_q;
  logic              full_q;
  logic [WIDE_W-1:0] rem_w, max_w;
  logic [PKT_W-1:0]  size_d;

  assign rem_w  = WIDE_W'(rem_i);
  assign max_w  = WIDE_W'(max_i);
  assign size_d = (rem_w < max_w) ? PKT_W'(rem_w) : max_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      full_q <= 1'b0;
    end else if (load_i) begin
      left_q <= size_d;
      full_q <= (rem_w >= max_w);
    end else if (beat_i) begin
      left_q <= left_q - PKT_W'(1);
    end
  end

  assign last_beat_o = beat_i && (left_q == PKT_W'(1));
  assign full_o      = full_q;

  // no byte is taken beyond the loaded packet size
  AST_PKT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    beat_i |-> left_q != '0); // R1
endmodule

// File: rtl/seg_fsm.sv
module seg_fsm
  import usb_seg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic multi_i,
  input  logic space_i,
  input  logic rem_zero_i,
  input  logic last_beat_i,
  input  logic full_i,
  output logic cfg_load_o,
  output logic pkt_load_o,
  output logic fill_o,
  output logic commit_o,
  output logic done_o
);
  seg_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    cfg_load_o = 1'b0;
    pkt_load_o = 1'b0;
    unique case (state_q)
      SEG_IDLE: if (start_i) begin
        cfg_load_o = 1'b1;
        state_d    = SEG_WAIT;
      end
      SEG_WAIT: if (space_i) begin
        if (rem_zero_i) state_d = SEG_NULL;
        else begin
          pkt_load_o = 1'b1;
          state_d    = SEG_FILL;
        end
      end
      SEG_FILL: if (last_beat_i) state_d = SEG_COMMIT;
      SEG_COMMIT: begin
        if (!multi_i)         state_d = SEG_DONE;
        else if (!rem_zero_i) state_d = SEG_WAIT;
        else if (full_i)      state_d = SEG_WAIT;
        else                  state_d = SEG_DONE;
      end
      SEG_NULL: state_d = SEG_DONE;
      SEG_DONE: state_d = SEG_IDLE;
      default:  state_d = SEG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEG_IDLE;
    else        state_q <= state_d;
  end

  assign fill_o   = (state_q == SEG_FILL);
  assign commit_o = (state_q == SEG_COMMIT) || (state_q == SEG_NULL);
  assign done_o   = (state_q == SEG_DONE);

  // a fill phase only opens after space was seen while waiting
  AST_FILL_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_o) |-> $past(space_i)); // R7
  // start is not taken outside idle
  AST_START_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q != SEG_IDLE) |=> state_q != SEG_WAIT || $past(state_q) != SEG_DONE); // R9
endmodule

// File: rtl/usb_bulk_tx_segmenter.sv
module usb_bulk_tx_segmenter #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 16,
  parameter int PKT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              multi_i,
  input  logic [LEN_W-1:0]  total_len_i,
  input  logic [PKT_W-1:0]  max_pkt_i,
  input  logic              fifo_space_i,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_ready_o,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              pkt_ready_o,
  output logic              done_irq_o
);
  logic             cfg_load, pkt_load, fill, commit, done;
  logic             beat, rem_zero, last_beat, full;
  logic             multi_q;
  logic [PKT_W-1:0] max_q;
  logic [LEN_W-1:0] rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      multi_q <= 1'b0;
      max_q   <= '0;
    end else if (cfg_load) begin
      multi_q <= multi_i;
      max_q   <= max_pkt_i;
    end
  end

  assign beat = fill && src_valid_i;

  seg_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .multi_i     (multi_q),
    .space_i     (fifo_space_i),
    .rem_zero_i  (rem_zero),
    .last_beat_i (last_beat),
    .full_i      (full),
    .cfg_load_o  (cfg_load),
    .pkt_load_o  (pkt_load),
    .fill_o      (fill),
    .commit_o    (commit),
    .done_o      (done)
  );

  seg_len_tracker #(.LEN_W(LEN_W)) u_len (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cfg_load),
    .len_i      (total_len_i),
    .beat_i     (beat),
    .rem_o      (rem),
    .rem_zero_o (rem_zero)
  );

  seg_pkt_tracker #(.LEN_W(LEN_W), .PKT_W(PKT_W)) u_pkt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (pkt_load),
    .rem_i       (rem),
    .max_i       (max_q),
    .beat_i      (beat),
    .last_beat_o (last_beat),
    .full_o      (full)
  );

  assign src_ready_o = fill;
  assign fifo_wr_o   = beat;
  assign fifo_data_o = src_data_i;
  assign pkt_ready_o = commit;
  assign done_irq_o  = done;

  // packet-ready is a strobe, never two cycles in a row
  AST_PKT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready_o |=> !pkt_ready_o); // R3
  // done always comes straight after a packet commit
  AST_DONE_AFTER_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq_o |-> $past(pkt_ready_o)); // R6
  // done is a single-cycle pulse
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq_o |=> !done_irq_o); // R6
  // no source byte is taken while a packet is being committed
  AST_NO_WR_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready_o |-> !fifo_wr_o); // R8
endmodule

// File: tb/tb_usb_bulk_tx_segmenter.sv
module tb_usb_bulk_tx_segmenter;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 16;
  localparam int PKT_W  = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              multi_i = 1'b0;
  logic [LEN_W-1:0]  total_len_i = '0;
  logic [PKT_W-1:0]  max_pkt_i = '0;
  logic              fifo_space_i = 1'b0;
  logic              src_valid_i = 1'b0;
  logic [DATA_W-1:0] src_data_i = '0;
  logic              src_ready_o, fifo_wr_o, pkt_ready_o, done_irq_o;
  logic [DATA_W-1:0] fifo_data_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int space_pct = 50;
  int valid_pct = 70;
  int stray_pct = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_bulk_tx_segmenter #(.DATA_W(DATA_W), .LEN_W(LEN_W), .PKT_W(PKT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .multi_i(multi_i),
    .total_len_i(total_len_i), .max_pkt_i(max_pkt_i), .fifo_space_i(fifo_space_i),
    .src_valid_i(src_valid_i), .src_data_i(src_data_i), .src_ready_o(src_ready_o),
    .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o), .pkt_ready_o(pkt_ready_o),
    .done_irq_o(done_irq_o)
  );

  // reference model: 0 idle, 1 wait space, 2 filling, 3 packet commit, 4 done
  int stage = 0;
  int left = 0;
  int plan[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage = 0;
      plan.delete();
    end else begin
      case (stage)
        0: if (start_i) begin
          int r, m;
          r = int'(total_len_i);
          m = int'(max_pkt_i);
          plan.delete();
          if (!multi_i) plan.push_back(r < m ? r : m);
          else if (r == 0) plan.push_back(0);
          else begin
            while (r > 0) begin
              plan.push_back(r < m ? r : m);
              r = r - (r < m ? r : m);
            end
            if (plan[$] == m) plan.push_back(0);
          end
          stage = 1;
        end
        1: if (fifo_space_i) begin
          left = plan.pop_front();
          stage = (left == 0) ? 3 : 2;
        end
        2: if (src_valid_i) begin
          left = left - 1;
          if (left == 0) stage = 3;
        end
        3: stage = (plan.size() != 0) ? 1 : 4;
        default: stage = 0;
      endcase
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic compare();
    logic ewr;
    ewr = (stage == 2) && src_valid_i;
    chk("R8 src_ready", src_ready_o, stage == 2);
    chk("R8 fifo_wr", fifo_wr_o, ewr);
    if (ewr) begin
      tests++;
      if (fifo_data_o !== src_data_i) begin
        fails++;
        $display("FAIL R8 fifo_data actual=%0h expected=%0h", fifo_data_o, src_data_i);
      end
    end
    chk("R1/R2/R3/R4/R5 pkt_ready", pkt_ready_o, stage == 3);
    chk("R6 done_irq", done_irq_o, stage == 4);
  endtask

  task automatic step();
    @(negedge clk);
    cycles++;
    compare();
    fifo_space_i = ($urandom_range(99) < space_pct);
    src_valid_i  = ($urandom_range(99) < valid_pct);
    src_data_i   = DATA_W'($urandom);
    // R9: stray start with unrelated settings while busy
    start_i      = ($urandom_range(99) < stray_pct);
    if (start_i) begin
      total_len_i = LEN_W'($urandom_range(40));
      max_pkt_i   = PKT_W'($urandom_range(1, 9));
      multi_i     = $urandom_range(1);
    end
  endtask

  task automatic xfer(input logic multi, input int len, input int mx);
    @(negedge clk);
    cycles++;
    compare();
    start_i = 1'b1;
    multi_i = multi;
    total_len_i = LEN_W'(len);
    max_pkt_i = PKT_W'(mx);
    step();
    while (stage != 0 && cycles < 150000) step();
    start_i = 1'b0;
    if (cycles >= 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=done");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 src_ready", src_ready_o, 1'b0);
    chk("R10 fifo_wr", fifo_wr_o, 1'b0);
    chk("R10 pkt_ready", pkt_ready_o, 1'b0);
    chk("R10 done_irq", done_irq_o, 1'b0);
    rst_n = 1'b1;
    // full throughput first
    space_pct = 100; valid_pct = 100;
    xfer(1'b1, 10, 4);   // R1 R2
    xfer(1'b1, 8, 4);    // R3
    xfer(1'b1, 0, 4);    // R4
    xfer(1'b0, 3, 8);    // R5
    space_pct = 40; valid_pct = 60;
    xfer(1'b0, 20, 8);   // R5 truncation
    xfer(1'b0, 0, 8);    // R5 zero
    xfer(1'b1, 5, 1);    // R3 size one
    xfer(1'b1, 64, 16);  // R3 R7
    xfer(1'b1, 7, 64);   // R2 single short
    stray_pct = 15;      // R9 stray starts
    xfer(1'b1, 24, 8);
    xfer(1'b1, 13, 5);
    for (int i = 0; i < 40; i++) begin
      space_pct = $urandom_range(10, 100);
      valid_pct = $urandom_range(10, 100);
      xfer($urandom_range(1), $urandom_range(60), $urandom_range(1, 12));
    end
    stray_pct = 0;
    repeat (3) step();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule